// File: doc/BRIEF.md
# Tunable-Capacitor Serial Control Slave

This block is the receiving end of a write-only three-wire control link that programs a 32-step tuning element. The enable, clock and data lines arrive asynchronously; they are brought into the fast system clock domain through multi-flop synchronisers. While the enable is high, every rising edge of the serial clock pushes one data bit into an eight-bit rolling window. The slave never counts bits, so the window always holds the eight most recent bits received.

When the enable falls, the window is copied into the active setting. The five low bits become the tuning state. The next bit up selects standby. The two top bits are reserved: a word with either reserved bit set raises an error flag but is still applied. Each commit emits a one-cycle update strobe. Several slaves can share the clock and data lines, with one enable line per slave, because serial clock edges are ignored while the enable is low.

Top module: `tcap_serial_slave`

## Requirements
- R1: After reset the tuning state is 0, standby is 0, the error flag is 0, and no update strobe is issued until a commit occurs.
- R2: While the synchronised enable is high, each serial clock rising edge captures one data bit. Words are sent most significant bit first. Bits 4..0 of the committed word drive the tuning state (0 = minimum, 31 = maximum).
- R3: The outputs change only on a commit. They hold their values while bits are being shifted in and while the link is idle.
- R4: A commit takes place when the synchronised enable falls. The new outputs and a strobe exactly one system clock wide appear after the third system clock rising edge that follows the enable going low at the input.
- R5: When more than eight bits arrive in one frame, only the last eight received are committed.
- R6: The window is not cleared between frames. A frame with fewer than eight bits commits the older bits moved up by the number of new bits.
- R7: Serial clock edges while the enable is low leave the window unchanged and produce no strobe.
- R8: If bit 7 or bit 6 of a committed word is 1, the error flag goes high and the word is still applied. The next word with both bits at 0 clears the flag.
- R9: Bit 5 of the committed word drives the standby output: 1 means low-current standby and 0 means active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_i | input | 1 | Serial enable (frame window), asynchronous |
| scl_i | input | 1 | Serial clock, asynchronous |
| sda_i | input | 1 | Serial data, asynchronous |
| tune_state_o | output | 5 | Active tuning state |
| standby_o | output | 1 | Active standby request |
| update_o | output | 1 | One-cycle strobe on each commit |
| frame_err_o | output | 1 | Last committed word had a reserved bit set |

## Verification
A bit lost or doubled in the rolling window is invisible until the next enable fall. At that point it shows up three system clocks later as a shifted tuning state, a wrong standby value or a spurious error flag. A window that stepped on a serial clock edge while the enable was low would only show up on a later commit that carries no new bits, so the bench includes such a frame with no clocks. A broken commit path shows up as outputs that move without a strobe, or as a strobe that does not return low on the following cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int WORD_W  = 8;
  localparam int STATE_W = 5;
  localparam int RSVD_W  = WORD_W - STATE_W - 1;

  typedef struct packed {
    logic [RSVD_W-1:0]  rsvd;
    logic               standby;
    logic [STATE_W-1:0] state;
  } tcap_word_t;

  // A word is malformed when any reserved bit is non-zero.
  function automatic logic word_is_malformed(input tcap_word_t w);
    return |w.rsvd;
  endfunction

  function automatic tcap_word_t raw_to_word(input logic [WORD_W-1:0] raw);
    return tcap_word_t'(raw);
  endfunction
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/tcap_shift.sv
module tcap_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] window_o
);
  logic [WORD_W-1:0] window_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        window_q <= '0;
    else if (shift_en) window_q <= {window_q[WORD_W-2:0], bit_i};
  end

  assign window_o = window_q;

  AST_SHIFT_LSB_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> window_q[0] == $past(bit_i)); // R2
  AST_WINDOW_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(window_q)); // R7
endmodule

// File: rtl/tcap_serial_slave.sv
module tcap_serial_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sen_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic [4:0] tune_state_o,
  output logic       standby_o,
  output logic       update_o,
  output logic       frame_err_o
);
  import tcap_pkg::*;

  localparam int LINE_N = 3;
  localparam int EDGE_N = 2;

  // Named internal events
  logic [LINE_N-1:0] lines_sync;
  logic              sen_lvl, scl_lvl, sda_lvl;
  logic [EDGE_N-1:0] edge_rise, edge_fall;
  logic              scl_rise, sen_fall;
  logic              shift_en, commit;
  logic [WORD_W-1:0] window;
  tcap_word_t        next_word;

  tcap_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sen_i, scl_i, sda_i}),
    .dout (lines_sync)
  );
  assign {sen_lvl, scl_lvl, sda_lvl} = lines_sync;

  tcap_edge #(.WIDTH(EDGE_N)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({sen_lvl, scl_lvl}),
    .rise (edge_rise),
    .fall (edge_fall)
  );
  assign scl_rise = edge_rise[0];
  assign sen_fall = edge_fall[1];

  assign shift_en = scl_rise & sen_lvl;
  assign commit   = sen_fall;

  tcap_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .bit_i   (sda_lvl),
    .window_o(window)
  );

  assign next_word = raw_to_word(window);

  logic [STATE_W-1:0] state_q;
  logic               standby_q, err_q, update_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      standby_q <= 1'b0;
      err_q     <= 1'b0;
      update_q  <= 1'b0;
    end else begin
      update_q <= commit;
      if (commit) begin
        state_q   <= next_word.state;
        standby_q <= next_word.standby;
        err_q     <= word_is_malformed(next_word);
      end
    end
  end

  assign tune_state_o = state_q;
  assign standby_o    = standby_q;
  assign frame_err_o  = err_q;
  assign update_o     = update_q;

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(tune_state_o) && $stable(standby_o) && $stable(frame_err_o))); // R3
  AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> update_o); // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o); // R4
  AST_ERR_TRACKS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (frame_err_o == $past(window[WORD_W-1:WORD_W-2] != 2'b00))); // R8
  AST_NO_SHIFT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_lvl |-> !shift_en); // R7
endmodule

// File: tb/tcap_serial_slave_test.sv
module tcap_serial_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sen = 1'b0, scl = 1'b0, sda = 1'b0;
  logic [4:0] st;
  logic       stby, upd, err;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tcap_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .sen_i(sen), .scl_i(scl), .sda_i(sda),
    .tune_state_o(st), .standby_o(stby), .update_o(upd), .frame_err_o(err)
  );

  // word, expected state, standby, error
  localparam logic [14:0] VECS [0:8] = '{
    {8'h00, 5'd0,  1'b0, 1'b0},
    {8'h1F, 5'd31, 1'b0, 1'b0},
    {8'h3F, 5'd31, 1'b1, 1'b0},
    {8'h20, 5'd0,  1'b1, 1'b0},
    {8'h15, 5'd21, 1'b0, 1'b0},
    {8'h2A, 5'd10, 1'b1, 1'b0},
    {8'h80, 5'd0,  1'b0, 1'b1},
    {8'h4B, 5'd11, 1'b0, 1'b1},
    {8'h0A, 5'd10, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sda = bits[i];
      repeat (2) @(negedge clk);
      scl = 1'b1;
      repeat (2) @(negedge clk);
      scl = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // Sends a frame, checks outputs held before the enable falls, then checks the commit.
  task automatic frame(input logic [15:0] bits, input int n, input logic [4:0] e_st,
                       input logic e_sb, input logic e_er, input string req);
    logic [4:0] old_st;
    old_st = st;
    @(negedge clk);
    sen = 1'b1;
    repeat (3) @(negedge clk);
    put_bits(bits, n);
    chk({req, " R3 state held before commit"}, {3'b0, st}, {3'b0, old_st});
    sen = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({req, " R4 no strobe before third edge"}, {7'b0, upd}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R4 strobe"}, {7'b0, upd}, 8'h01);
    chk({req, " R2 state"}, {3'b0, st}, {3'b0, e_st});
    chk({req, " R9 standby"}, {7'b0, stby}, {7'b0, e_sb});
    chk({req, " R8 error"}, {7'b0, err}, {7'b0, e_er});
    @(negedge clk);
    chk({req, " R4 strobe one cycle"}, {7'b0, upd}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 state", {3'b0, st}, 8'h00);
    chk("R1 standby", {7'b0, stby}, 8'h00);
    chk("R1 error", {7'b0, err}, 8'h00);
    chk("R1 strobe", {7'b0, upd}, 8'h00);

    for (int v = 0; v < 9; v++)
      frame({8'h00, VECS[v][14:7]}, 8, VECS[v][6:2], VECS[v][1], VECS[v][0], "vec");

    // R5: twelve bits, last eight 0x2C apply
    frame(16'h0A2C, 12, 5'd12, 1'b1, 1'b0, "R5 long frame");
    // R6: three bits 101 after 0x2C -> window 0x65
    frame(16'h0005, 3, 5'd5, 1'b1, 1'b1, "R6 short frame");

    // R7: clock edges while the enable is low are ignored
    frame(16'h0007, 8, 5'd7, 1'b0, 1'b0, "R7 setup");
    begin
      int pulses = 0;
      sda = 1'b1;
      for (int k = 0; k < 10; k++) begin
        scl = 1'b1;
        repeat (2) @(negedge clk) if (upd) pulses++;
        scl = 1'b0;
        repeat (2) @(negedge clk) if (upd) pulses++;
      end
      repeat (4) @(negedge clk) if (upd) pulses++;
      chk("R7 no strobe while disabled", pulses[7:0], 8'h00);
      chk("R7 state unchanged", {3'b0, st}, 8'h07);
    end
    // Frame with no clocks commits the untouched window
    frame(16'h0000, 0, 5'd7, 1'b0, 1'b0, "R7 empty frame");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule